// File: doc/BRIEF.md
# Serial Non-Volatile Memory Command Engine

This block is the serial front end of a byte-wide non-volatile memory that is reached over a four-wire SPI link. It samples chip select, serial clock, serial data in and a hold input with the system clock. It collects an 8-bit command code. Depending on the command it then gathers a 16-bit address and moves data bytes. The read path sends array bytes or the status byte out on a serial line that has a separate output-enable. The write path fills a page buffer. When the transfer closes cleanly, the buffer is committed to the array in one self-timed programming cycle.

The array sits behind a plain synchronous RAM port. A read request returns its data one system clock later, and a write strobe stores one byte. While the programming cycle runs, a busy flag is raised both on a port and in the status byte. During that time only status polling is honoured.

Top module: `spi_ee_engine`

## Requirements
- R1: While chip select (`cs_n`) is high, `so_oe` is 0 and serial input is ignored. A command begins only on a falling chip select, and it is ended by the following rise.
- R2: Serial input is taken on rising `sck` edges and output changes on falling `sck` edges. Every field is sent most significant bit first.
- R3: The command codes are 0x06 (set write enable), 0x04 (clear write enable), 0x05 (read status), 0x01 (write status), 0x03 (read array) and 0x02 (write array).
- R4: The status byte has bit 0 as busy, bit 1 as the write-enable latch and bits 7:2 as configuration bits. Code 0x06 sets the latch and code 0x04 clears it.
- R5: A read takes a 16-bit address, of which only the low ADDR_W bits are used. It then returns bytes from consecutive addresses and wraps from the top of the array to address 0.
- R6: A write is accepted only with the latch set. Each data byte goes to the next location inside the current PAGE_BYTES page, wrapping within the page, and a later byte replaces an earlier one at the same location.
- R7: Programming starts only when chip select rises after at least one complete data byte. A transfer that ends in the middle of a byte programs nothing and leaves the latch unchanged.
- R8: `busy` is high for exactly PROG_CYCLES system clocks from the start of programming.
- R9: While busy, every command except read status is ignored. Such a read drives nothing and such a latch command has no effect.
- R10: The latch is cleared when a write or status-write programming cycle ends.
- R11: After an unknown command code, `so_oe` stays 0 and the rest of the transfer, including valid-looking codes, is ignored until chip select goes high and then low again.
- R12: Hold low, taken while `sck` is low, freezes the bit position and ignores `sck` edges. Hold high, taken while `sck` is low, resumes from the same bit.
- R13: A status write needs the latch set. Its first data byte updates bits 7:2 of the status byte, and it starts a programming cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Transfer pause, active low |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |
| busy | output | 1 | Programming cycle in progress |
| mem_addr | output | ADDR_W | Array address |
| mem_re | output | 1 | Array read request |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, valid one clock after `mem_re` |

## Verification
The bench writes every page of a small array. The write lengths vary, and some of them run past the page end. It then reads the whole array back in one stream that crosses the top of the array. A design that wrapped writes across pages, or reads at the page end, would return wrong bytes at the seams. Targeted transfers cover the remaining cases:
- an unknown code followed by a set-enable code, where an engine that kept decoding would show the latch set
- a transfer cut off mid-byte, which must not program
- a set-enable command and a read issued while busy, which a careless engine would act on
- a hold pause with toggling clock and data, which would shift garbage into the byte if the pause leaked

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_RSTAT,
    ST_WSTAT,
    ST_SKIP
  } ee_state_t;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  output logic cs_act,
  output logic cs_start,
  output logic cs_end,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s,
  output logic held
);

  logic [1:0] cs_sr, sck_sr, si_sr, hold_sr;
  logic       cs_d, sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sr   <= 2'b11;
      sck_sr  <= 2'b00;
      si_sr   <= 2'b00;
      hold_sr <= 2'b11;
      cs_d    <= 1'b1;
      sck_d   <= 1'b0;
      held    <= 1'b0;
    end else begin
      cs_sr   <= {cs_sr[0], cs_n};
      sck_sr  <= {sck_sr[0], sck};
      si_sr   <= {si_sr[0], si};
      hold_sr <= {hold_sr[0], hold_n};
      cs_d    <= cs_sr[1];
      sck_d   <= sck_sr[1];
      // pause state may only move while the serial clock is low
      if (!sck_sr[1]) held <= !hold_sr[1];
    end
  end

  assign cs_act   = !cs_sr[1];
  assign cs_start = cs_d && !cs_sr[1];
  assign cs_end   = !cs_d && cs_sr[1];
  assign sck_rise = sck_sr[1] && !sck_d && !held && cs_act;
  assign sck_fall = !sck_sr[1] && sck_d && !held && cs_act;
  assign si_s     = si_sr[1];

  // R12
  hold_low_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held != $past(held)) |-> !$past(sck_sr[1]));

endmodule

// File: rtl/spi_ee_prog.sv
module spi_ee_prog #(
  parameter int ADDR_W      = 14,
  parameter int PAGE_BYTES  = 64,
  parameter int PROG_CYCLES = 250000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         wr_en,
  input  logic [$clog2(PAGE_BYTES)-1:0] wr_slot,
  input  logic [7:0]                   wr_data,
  input  logic                         start,
  input  logic                         use_page,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_base,
  output logic                         busy,
  output logic                         done,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [7:0]                   mem_wdata
);

  localparam int PW = $clog2(PAGE_BYTES);
  localparam int BW = ADDR_W - PW;
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld;
  logic [CW-1:0]         cnt;
  logic                  use_q;
  logic [BW-1:0]         base_q;
  logic [PW-1:0]         slot;
  logic                  in_page;

  always_ff @(posedge clk) begin
    if (wr_en) pbuf[wr_slot] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= '0;
      busy   <= 1'b0;
      cnt    <= '0;
      use_q  <= 1'b0;
      base_q <= '0;
    end else begin
      if (clr) vld <= '0;
      else if (wr_en) vld[wr_slot] <= 1'b1;
      if (start && !busy) begin
        busy   <= 1'b1;
        cnt    <= '0;
        use_q  <= use_page;
        base_q <= page_base;
      end else if (busy) begin
        if (done) busy <= 1'b0;
        else cnt <= cnt + 1'b1;
      end
    end
  end

  assign slot      = cnt[PW-1:0];
  assign in_page   = cnt < CW'(PAGE_BYTES);
  assign done      = busy && (cnt == CW'(PROG_CYCLES - 1));
  assign mem_we    = busy && use_q && in_page && vld[slot];
  assign mem_addr  = {base_q, slot};
  assign mem_wdata = pbuf[slot];

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R7
  buf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !busy);

endmodule

// File: rtl/spi_ee_engine.sv
module spi_ee_engine
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int PAGE_BYTES  = 64,
  parameter int PROG_CYCLES = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);

  localparam int PW = $clog2(PAGE_BYTES);
  localparam int BW = ADDR_W - PW;
  localparam int SW = ADDR_W - 1;

  function automatic logic [ADDR_W-1:0] next_rd_addr(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [PW-1:0] next_slot(input logic [PW-1:0] s);
    return s + 1'b1;
  endfunction

  logic cs_act, cs_start, cs_end, sck_rise, sck_fall, si_s, held;

  spi_ee_sync u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .cs_act(cs_act), .cs_start(cs_start), .cs_end(cs_end),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s), .held(held)
  );

  ee_state_t   state;
  logic [3:0]  bit_cnt;
  logic [SW-1:0] shin;
  logic [7:0]  op;
  logic [ADDR_W-1:0] addr;
  logic [7:0]  shout;
  logic        so_q;
  logic [2:0]  out_cnt;
  logic        rd_req, rd_pend;
  logic        wel;
  logic [5:0]  cfg;
  logic [5:0]  stat_byte;
  logic [PW-1:0] slot;
  logic [BW-1:0] page;
  logic        got_byte;

  logic [7:0]  rx8;
  logic [ADDR_W-1:0] rx_addr;
  logic [7:0]  status_byte;
  logic        rx_rise;
  logic        op_done, byte_done;
  logic        buf_clr, buf_wr;
  logic        commit_mem, commit_stat;
  logic        prog_busy, prog_done, prog_we;
  logic [ADDR_W-1:0] prog_addr;
  logic [7:0]  prog_wdata;

  assign rx8         = {shin[6:0], si_s};
  assign rx_addr     = {shin, si_s};
  assign status_byte = {cfg, wel, prog_busy};
  assign rx_rise     = sck_rise && !cs_start;
  assign op_done     = rx_rise && state == ST_OPC && bit_cnt == 4'd7;
  assign byte_done   = rx_rise && bit_cnt == 4'd7;
  assign buf_clr     = op_done && rx8 == OP_WRITE && wel && !prog_busy;
  assign buf_wr      = byte_done && state == ST_WDATA;
  assign commit_mem  = cs_end && state == ST_WDATA && bit_cnt == 4'd0 && got_byte;
  assign commit_stat = cs_end && state == ST_WSTAT && bit_cnt == 4'd0 && got_byte;

  spi_ee_prog #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr), .wr_slot(slot),
    .wr_data(rx8), .start(commit_mem || commit_stat), .use_page(commit_mem),
    .page_base(page), .busy(prog_busy), .done(prog_done), .mem_we(prog_we),
    .mem_addr(prog_addr), .mem_wdata(prog_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  bit_cnt <= '0;  shin <= '0;   op <= '0;
      addr <= '0;        shout <= '0;    so_q <= 1'b0; out_cnt <= '0;
      rd_req <= 1'b0;    rd_pend <= 1'b0; wel <= 1'b0; cfg <= '0;
      stat_byte <= '0;   slot <= '0;     page <= '0;   got_byte <= 1'b0;
    end else begin
      rd_req  <= 1'b0;
      rd_pend <= rd_req;
      if (rd_pend) shout <= mem_rdata;
      if (prog_done) wel <= 1'b0;
      if (cs_end) begin
        state <= ST_IDLE;
        if (commit_stat) cfg <= stat_byte;
      end else if (cs_start) begin
        state    <= ST_OPC;
        bit_cnt  <= '0;
        got_byte <= 1'b0;
      end else if (sck_rise) begin
        shin    <= {shin[SW-2:0], si_s};
        bit_cnt <= bit_cnt + 4'd1;
        case (state)
          ST_OPC: if (bit_cnt == 4'd7) begin
            bit_cnt <= '0;
            op      <= rx8;
            if (prog_busy && rx8 != OP_RDSR) state <= ST_SKIP;
            else begin
              case (rx8)
                OP_WREN:  begin wel <= 1'b1; state <= ST_SKIP; end
                OP_WRDI:  begin wel <= 1'b0; state <= ST_SKIP; end
                OP_RDSR:  begin shout <= status_byte; out_cnt <= '0; state <= ST_RSTAT; end
                OP_WRSR:  state <= wel ? ST_WSTAT : ST_SKIP;
                OP_READ:  state <= ST_ADDR;
                OP_WRITE: state <= wel ? ST_ADDR : ST_SKIP;
                default:  state <= ST_SKIP;
              endcase
            end
          end
          ST_ADDR: if (bit_cnt == 4'd15) begin
            bit_cnt <= '0;
            addr    <= rx_addr;
            if (op == OP_READ) begin
              rd_req  <= 1'b1;
              out_cnt <= '0;
              state   <= ST_RDATA;
            end else begin
              slot  <= rx_addr[PW-1:0];
              page  <= rx_addr[ADDR_W-1:PW];
              state <= ST_WDATA;
            end
          end
          ST_WDATA: if (bit_cnt == 4'd7) begin
            bit_cnt  <= '0;
            slot     <= next_slot(slot);
            got_byte <= 1'b1;
          end
          ST_WSTAT: if (bit_cnt == 4'd7) begin
            bit_cnt <= '0;
            if (!got_byte) stat_byte <= rx8[7:2];
            got_byte <= 1'b1;
          end
          default: ;
        endcase
      end else if (sck_fall && (state == ST_RDATA || state == ST_RSTAT)) begin
        so_q    <= shout[7];
        shout   <= {shout[6:0], 1'b0};
        out_cnt <= out_cnt + 3'd1;
        if (out_cnt == 3'd7) begin
          if (state == ST_RDATA) begin
            addr   <= next_rd_addr(addr);
            rd_req <= 1'b1;
          end else begin
            shout <= status_byte;
          end
        end
      end
    end
  end

  assign so        = so_q;
  assign so_oe     = state == ST_RDATA || state == ST_RSTAT;
  assign busy      = prog_busy;
  assign mem_re    = rd_req;
  assign mem_we    = prog_we;
  assign mem_addr  = prog_busy ? prog_addr : addr;
  assign mem_wdata = prog_wdata;

  // R1
  cs_high_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_act && !$past(cs_act)) |-> !so_oe);

  // R11
  skip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP && !cs_end) |=> state == ST_SKIP);

  // R9
  busy_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_busy |-> !rd_req);

  // R10
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> !wel);

  // R12
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !cs_start && !cs_end) |=> $stable(bit_cnt));

endmodule

// File: tb/spi_ee_engine_test.sv
module spi_ee_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int H          = 6;
  localparam int AW         = 8;
  localparam int PB         = 16;
  localparam int PC         = 2000;
  localparam int DEPTH      = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, busy, mem_re, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] ram [DEPTH];
  logic [7:0] expm [DEPTH];
  logic [5:0] cfg_exp = '0;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;
  bit  oe_seen;
  logic [7:0] dummy;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_ee_engine #(.ADDR_W(AW), .PAGE_BYTES(PB), .PROG_CYCLES(PC)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .so(so), .so_oe(so_oe), .busy(busy), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exv);
    end
  endtask

  function automatic logic [7:0] pat(input int p, input int i);
    return 8'(p * 37 + i * 11 + 5);
  endfunction

  function automatic logic [7:0] st_exp(input bit wel, input bit bsy);
    return {cfg_exp, wel, bsy};
  endfunction

  task automatic cs_lo();
    cs_n = 1'b0;
    tick(H);
  endtask

  task automatic cs_hi();
    tick(H);
    cs_n = 1'b1;
    tick(H);
  endtask

  task automatic xbits(input logic [7:0] d, input int k, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - k; i--) begin
      si = d[i];
      tick(H);
      r[i] = so;
      oe_seen = oe_seen | so_oe;
      sck = 1'b1;
      tick(H);
      sck = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
    xbits(d, 8, r);
  endtask

  task automatic xbyte_hold(input logic [7:0] d, input int k);
    for (int i = 7; i >= 0; i--) begin
      if (i == 7 - k) begin
        hold_n = 1'b0;
        tick(H);
        for (int j = 0; j < 3; j++) begin
          si = ~si;
          sck = 1'b1;
          tick(H);
          sck = 1'b0;
          tick(H);
        end
        hold_n = 1'b1;
        tick(H);
      end
      si = d[i];
      tick(H);
      sck = 1'b1;
      tick(H);
      sck = 1'b0;
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    cs_lo();
    xbyte(op, dummy);
    cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] s);
    cs_lo();
    xbyte(8'h05, dummy);
    xbyte(8'h00, s);
    cs_hi();
  endtask

  task automatic wait_idle();
    while (busy) tick(1);
  endtask

  // closes the transfer and measures how long busy stays high (0 if it never rises)
  task automatic close_and_measure(output int blen);
    int w;
    tick(H);
    cs_n = 1'b1;
    blen = 0;
    w = 0;
    while (!busy && w < 30) begin tick(1); w++; end
    while (busy) begin tick(1); blen++; end
    tick(H);
  endtask

  task automatic wr_page(input logic [15:0] a, input int n, input int p, output int blen);
    cs_lo();
    xbyte(8'h02, dummy);
    xbyte(a[15:8], dummy);
    xbyte(a[7:0], dummy);
    for (int i = 0; i < n; i++) xbyte(pat(p, i), dummy);
    close_and_measure(blen);
  endtask

  task automatic model_write(input logic [15:0] a, input int n, input int p);
    for (int i = 0; i < n; i++)
      expm[{a[AW-1:4], 4'((a[3:0] + i) % PB)}] = pat(p, i);
  endtask

  task automatic rd_chk(input logic [15:0] a, input int n, input string tag);
    logic [7:0] r;
    cs_lo();
    xbyte(8'h03, dummy);
    xbyte(a[15:8], dummy);
    xbyte(a[7:0], dummy);
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] ea;
      xbyte(8'h00, r);
      ea = AW'((a[AW-1:0] + i) % DEPTH);
      chk(r == expm[ea], tag, r, expm[ea]);
    end
    cs_hi();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    int blen;
    for (int i = 0; i < DEPTH; i++) begin ram[i] = '0; expm[i] = '0; end
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1 R4: reset state
    chk(so_oe == 1'b0, "R1 reset so_oe", so_oe, 0);
    chk(busy == 1'b0, "R8 reset busy", busy, 0);
    rdsr(s);
    chk(s == 8'h00, "R4 reset status", s, 8'h00);

    // R3 R4: latch set and clear codes
    cmd(8'h06);
    rdsr(s);
    chk(s == st_exp(1, 0), "R4 set enable", s, st_exp(1, 0));
    cmd(8'h04);
    rdsr(s);
    chk(s == st_exp(0, 0), "R4 clear enable", s, st_exp(0, 0));

    // R6 R8 R10: write every page with varied offsets and lengths, some wrapping
    for (int p = 0; p < DEPTH / PB; p++) begin
      logic [15:0] a;
      int n;
      a = {8'(p * 29 + 3), 4'(p), 4'((p * 5) % PB)};
      n = 1 + (p * 7) % 20;
      cmd(8'h06);
      wr_page(a, n, p, blen);
      model_write(a, n, p);
      chk(blen == PC, "R8 busy length", blen, PC);
      if (p == 0) begin
        rdsr(s);
        chk(s == st_exp(0, 0), "R10 enable cleared after write", s, st_exp(0, 0));
      end
    end

    // R2 R5 R6: full stream read crossing the top of the array
    rd_chk(16'h3780, DEPTH, "R2 R5 R6 readback");
    chk(so_oe == 1'b0, "R1 so_oe after chip select high", so_oe, 0);
    // R5: upper address bits ignored, wrap at top
    rd_chk(16'hABFE, 4, "R5 wrap");

    // R11: unknown code, then codes that must be ignored
    cs_lo();
    xbyte(8'hAA, dummy);
    oe_seen = 1'b0;
    xbyte(8'h03, dummy);
    xbyte(8'h00, dummy);
    xbyte(8'h06, dummy);
    xbyte(8'h00, dummy);
    cs_hi();
    chk(oe_seen == 1'b0, "R11 output quiet", oe_seen, 0);
    rdsr(s);
    chk(s == st_exp(0, 0), "R11 enable ignored", s, st_exp(0, 0));

    // R6: write without the latch has no effect
    wr_page(16'h0060, 1, 99, blen);
    chk(blen == 0, "R6 no program without enable", blen, 0);
    rd_chk(16'h0060, 1, "R6 unchanged without enable");

    // R7: transfer cut mid-byte programs nothing and keeps the latch
    cmd(8'h06);
    cs_lo();
    xbyte(8'h02, dummy);
    xbyte(8'h00, dummy);
    xbyte(8'h50, dummy);
    xbyte(8'h77, dummy);
    xbits(8'hC3, 3, dummy);
    close_and_measure(blen);
    chk(blen == 0, "R7 partial byte no program", blen, 0);
    rdsr(s);
    chk(s == st_exp(1, 0), "R7 latch kept", s, st_exp(1, 0));
    rd_chk(16'h0050, 1, "R7 array unchanged");
    cmd(8'h04);

    // R9: commands during busy
    cmd(8'h06);
    cs_lo();
    xbyte(8'h02, dummy);
    xbyte(8'h00, dummy);
    xbyte(8'h40, dummy);
    xbyte(8'h11, dummy);
    tick(H);
    cs_n = 1'b1;
    tick(H);
    expm[8'h40] = 8'h11;
    rdsr(s);
    chk(s == st_exp(1, 1), "R9 status during busy", s, st_exp(1, 1));
    cs_lo();
    xbyte(8'h03, dummy);
    xbyte(8'h00, dummy);
    xbyte(8'h40, dummy);
    oe_seen = 1'b0;
    xbyte(8'h00, dummy);
    cs_hi();
    chk(oe_seen == 1'b0, "R9 read ignored while busy", oe_seen, 0);
    cmd(8'h06);
    chk(busy == 1'b1, "R9 still busy", busy, 1);
    wait_idle();
    rdsr(s);
    chk(s == st_exp(0, 0), "R9 R10 enable ignored while busy", s, st_exp(0, 0));
    rd_chk(16'h0040, 1, "R9 write committed");

    // R13: status write with and without the latch
    cmd(8'h06);
    cs_lo();
    xbyte(8'h01, dummy);
    xbyte(8'hA7, dummy);
    close_and_measure(blen);
    cfg_exp = 6'(8'hA7 >> 2);
    chk(blen == PC, "R13 status write busy", blen, PC);
    rdsr(s);
    chk(s == st_exp(0, 0), "R13 R10 status written", s, st_exp(0, 0));
    cs_lo();
    xbyte(8'h01, dummy);
    xbyte(8'h58, dummy);
    close_and_measure(blen);
    chk(blen == 0, "R13 no cycle without enable", blen, 0);
    rdsr(s);
    chk(s == st_exp(0, 0), "R13 status kept", s, st_exp(0, 0));

    // R12: hold pause in the middle of a data byte
    cmd(8'h06);
    cs_lo();
    xbyte(8'h02, dummy);
    xbyte(8'h00, dummy);
    xbyte(8'h30, dummy);
    xbyte_hold(8'h5A, 3);
    close_and_measure(blen);
    expm[8'h30] = 8'h5A;
    chk(blen == PC, "R12 write after hold", blen, PC);
    rd_chk(16'h0030, 1, "R12 held byte intact");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule